// File: doc/BRIEF.md
# Write-Merging Store Buffer with Burst Drain

This block sits between a processor's store port and a 64-bit write address channel and write data channel of the AXI kind. Each store carries a byte address, a size code, up to 32 bits of right-justified data and a flag that marks device or strongly ordered memory. Stores to normal memory are not sent at once. The block gathers them into a small set of doubleword entries. Each entry has a doubleword tag, 64 data bits and a byte-valid mask. Later bytes replace earlier ones, so an overwritten store never reaches the bus.

A drain starts when every entry is in use, when `flush` is high, or when a device store is waiting at the input. A drain emits one incrementing burst of 64-bit beats. The burst starts at the lowest buffered doubleword and runs up to the highest buffered doubleword in the same 32-byte aligned block. A doubleword inside that run with no buffered bytes still gets a beat, with all strobes low. Device stores skip the entries entirely. Each one becomes a single-beat transaction at its own size, in program order, and only after the buffer is empty.

The store input follows valid/ready rules. A store is taken on a rising edge where `st_valid` and `st_ready` are both high. Until then the producer holds `st_valid` and all store fields steady. `st_ready` may depend on `st_valid` and `st_device` in the same cycle. On the output side, `aw_valid` and `w_valid` stay high with steady payloads until the matching ready is seen. Either ready may be held low for any number of cycles.

Top module: `wmerge_store_buf`

## Requirements
- R1: A store is accepted only on an edge where `st_valid` and `st_ready` are both high. `st_ready` is low while a transaction is being issued, and low while a drain is being requested.
- R2: A device store (`st_device`=1) gives one address transfer. Its `aw_addr` is the store address, `aw_len`=0 and `aw_burst`=2'b01 (incrementing). `aw_size` equals the store size code: 0 for a byte, 1 for a halfword, 2 for a word.
- R3: A device store's single beat has `w_last`=1. Its strobes are the lanes the store covers: 8'b1, 8'b11 or 8'b1111 for the three sizes, shifted left by address bits [2:0]. Its data is the store data shifted left by 8 times address bits [2:0].
- R4: Device stores reach the bus in program order, one transaction each, and none is dropped or combined.
- R5: Normal stores to the same doubleword share one entry. The beat for that doubleword carries the OR of their lane masks and each store's bytes in its own lanes.
- R6: A later normal store to a byte already buffered replaces that byte. The earlier value never appears on the bus.
- R7: A normal-memory burst has `aw_addr` equal to the lowest buffered doubleword address, `aw_size`=3 and `aw_burst`=2'b01. `aw_len` is the highest buffered doubleword index in that same 32-byte block minus the lowest one. Later bursts follow in ascending address order.
- R8: Inside a burst, a doubleword with no buffered bytes is sent as a beat with `w_strb`=0.
- R9: A drain starts only when all 4 entries hold data, when `flush` is high, or when a device store waits. Each drain sends one burst. Entries below capacity with no trigger cause no bus activity.
- R10: A device store is not accepted while any normal entry is buffered. Pending normal data goes to the bus first.
- R11: The address handshake of a transaction completes before its first data beat. `w_last` is high exactly on the final beat (`aw_len`+1 beats).
- R12: While `aw_valid` or `w_valid` waits on its ready, it stays high and its payload stays unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| st_valid | input | 1 | Store request valid |
| st_ready | output | 1 | Store accepted this cycle when high with st_valid |
| st_addr | input | 32 | Store byte address |
| st_size | input | 2 | Store size code: 0 byte, 1 halfword, 2 word |
| st_data | input | 32 | Store data, right-justified |
| st_device | input | 1 | 1 for device or strongly ordered memory |
| flush | input | 1 | Level request to drain buffered entries |
| aw_valid | output | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | output | 32 | Transaction start address |
| aw_len | output | 8 | Beats minus one |
| aw_size | output | 3 | Log2 of beat bytes |
| aw_burst | output | 2 | Burst type, always incrementing (2'b01) |
| w_valid | output | 1 | Write data valid |
| w_ready | input | 1 | Write data ready |
| w_data | output | 64 | Beat data |
| w_strb | output | 8 | Byte lane enables |
| w_last | output | 1 | Final beat of the transaction |

## Verification
The assertions assume that every store is naturally aligned, so its address offset is a multiple of its size, and that the size code is never 3. Under those two conditions the strobe count of a device beat matches its `aw_size`. They also assume that store fields stay steady while a request waits. The bench only uses aligned addresses and size codes 0 to 2, and it changes store fields only at a falling edge once the previous store has been taken. It also drives both ready inputs through a fixed stalling pattern, which exercises the hold and ordering properties under back-pressure.

// File: rtl/wsb_pkg.sv
package wsb_pkg;
  localparam int DW_OFS_W = 3;
  localparam logic [2:0] AXSIZE_DW = 3'd3;
  localparam logic [1:0] BURST_INCR = 2'b01;

  typedef enum logic [2:0] {
    S_IDLE, S_BAW, S_BW, S_DAW, S_DW
  } issue_state_e;

  function automatic logic [7:0] lane_mask(input logic [1:0] size, input logic [2:0] ofs);
    logic [7:0] base;
    case (size)
      2'd0: base = 8'h01;
      2'd1: base = 8'h03;
      default: base = 8'h0F;
    endcase
    return base << ofs;
  endfunction

  function automatic logic [63:0] lane_data(input logic [31:0] d, input logic [2:0] ofs);
    return {32'h0, d} << {ofs, 3'b000};
  endfunction

  function automatic logic [63:0] byte_expand(input logic [7:0] m);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = {8{m[b]}};
    return r;
  endfunction
endpackage

// File: rtl/wsb_entry_bank.sv
module wsb_entry_bank import wsb_pkg::*; #(
  parameter int NUM_ENT = 4,
  parameter int TAG_W = 29
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            wr_en,
  input  logic [TAG_W-1:0]                wr_tag,
  input  logic [7:0]                      wr_mask,
  input  logic [63:0]                     wr_data,
  input  logic                            free_en,
  input  logic [TAG_W-1:0]                rd_tag,
  output logic [NUM_ENT-1:0]              ent_valid,
  output logic [NUM_ENT-1:0][TAG_W-1:0]   ent_tag,
  output logic                            wr_hit,
  output logic                            has_free,
  output logic                            rd_hit,
  output logic [63:0]                     rd_data,
  output logic [7:0]                      rd_mask
);
  logic [NUM_ENT-1:0]       hit_v;
  logic [NUM_ENT-1:0]       alloc_oh;
  logic [NUM_ENT-1:0][7:0]  mask_a;
  logic [NUM_ENT-1:0][63:0] data_a;
  logic [63:0]              wr_bits;

  assign wr_bits = byte_expand(wr_mask);

  always_comb begin
    logic taken;
    taken = 1'b0;
    for (int i = 0; i < NUM_ENT; i++) begin
      alloc_oh[i] = !ent_valid[i] && !taken;
      taken = taken | !ent_valid[i];
    end
  end

  assign wr_hit   = |hit_v;
  assign has_free = !(&ent_valid);

  genvar g;
  generate
    for (g = 0; g < NUM_ENT; g++) begin : g_ent
      logic             v_q;
      logic [TAG_W-1:0] t_q;
      logic [7:0]       m_q;
      logic [63:0]      d_q;
      logic             take;

      assign hit_v[g] = v_q && (t_q == wr_tag);
      assign take     = wr_en && (hit_v[g] || (!wr_hit && alloc_oh[g]));

      always_ff @(posedge clk) begin
        if (!rst_n) begin
          v_q <= 1'b0;
          t_q <= '0;
          m_q <= '0;
          d_q <= '0;
        end else if (take) begin
          v_q <= 1'b1;
          t_q <= wr_tag;
          m_q <= (hit_v[g] ? m_q : 8'h00) | wr_mask;
          d_q <= ((hit_v[g] ? d_q : 64'h0) & ~wr_bits) | (wr_data & wr_bits);
        end else if (free_en && v_q && (t_q == rd_tag)) begin
          v_q <= 1'b0;
        end
      end

      assign ent_valid[g] = v_q;
      assign ent_tag[g]   = t_q;
      assign mask_a[g]    = m_q;
      assign data_a[g]    = d_q;
    end
  endgenerate

  always_comb begin
    rd_hit  = 1'b0;
    rd_data = '0;
    rd_mask = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (ent_valid[i] && ent_tag[i] == rd_tag) begin
        rd_hit  = 1'b1;
        rd_data = data_a[i];
        rd_mask = mask_a[i];
      end
    end
  end
endmodule

// File: rtl/wsb_burst_plan.sv
module wsb_burst_plan #(
  parameter int NUM_ENT = 4,
  parameter int TAG_W = 29,
  parameter int BEAT_W = 2
) (
  input  logic [NUM_ENT-1:0]            ent_valid,
  input  logic [NUM_ENT-1:0][TAG_W-1:0] ent_tag,
  output logic                          any_valid,
  output logic                          full,
  output logic [TAG_W-1:0]              base_tag,
  output logic [BEAT_W-1:0]             last_off
);
  logic [BEAT_W-1:0] off_v;

  assign full = &ent_valid;

  always_comb begin
    any_valid = 1'b0;
    base_tag  = '1;
    for (int i = 0; i < NUM_ENT; i++) begin
      if (ent_valid[i] && (!any_valid || ent_tag[i] < base_tag)) begin
        base_tag  = ent_tag[i];
        any_valid = 1'b1;
      end
    end
  end

  always_comb begin
    last_off = '0;
    off_v    = '0;
    for (int i = 0; i < NUM_ENT; i++) begin
      off_v = ent_tag[i][BEAT_W-1:0] - base_tag[BEAT_W-1:0];
      if (ent_valid[i] && (ent_tag[i][TAG_W-1:BEAT_W] == base_tag[TAG_W-1:BEAT_W])
          && off_v > last_off)
        last_off = off_v;
    end
  end
endmodule

// File: rtl/wsb_issue.sv
module wsb_issue import wsb_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int TAG_W = 29,
  parameter int BEAT_W = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drain_req,
  input  logic [TAG_W-1:0]  plan_base,
  input  logic [BEAT_W-1:0] plan_last,
  input  logic              dev_take,
  input  logic [ADDR_W-1:0] dev_addr,
  input  logic [1:0]        dev_size,
  input  logic [63:0]       dev_data,
  input  logic [7:0]        dev_strb,
  input  logic              rd_hit,
  input  logic [63:0]       rd_data,
  input  logic [7:0]        rd_mask,
  input  logic              aw_ready,
  input  logic              w_ready,
  output logic              idle,
  output logic [TAG_W-1:0]  rd_tag,
  output logic              free_en,
  output logic              aw_valid,
  output logic [ADDR_W-1:0] aw_addr,
  output logic [7:0]        aw_len,
  output logic [2:0]        aw_size,
  output logic [1:0]        aw_burst,
  output logic              w_valid,
  output logic [63:0]       w_data,
  output logic [7:0]        w_strb,
  output logic              w_last
);
  issue_state_e      state;
  logic [TAG_W-1:0]  base_r;
  logic [BEAT_W-1:0] last_r;
  logic [BEAT_W-1:0] cnt;
  logic [ADDR_W-1:0] dev_addr_r;
  logic [1:0]        dev_size_r;
  logic [63:0]       dev_data_r;
  logic [7:0]        dev_strb_r;
  logic              beat_last;

  assign beat_last = (cnt == last_r);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state      <= S_IDLE;
      base_r     <= '0;
      last_r     <= '0;
      cnt        <= '0;
      dev_addr_r <= '0;
      dev_size_r <= '0;
      dev_data_r <= '0;
      dev_strb_r <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (dev_take) begin
            dev_addr_r <= dev_addr;
            dev_size_r <= dev_size;
            dev_data_r <= dev_data;
            dev_strb_r <= dev_strb;
            state      <= S_DAW;
          end else if (drain_req) begin
            base_r <= plan_base;
            last_r <= plan_last;
            cnt    <= '0;
            state  <= S_BAW;
          end
        end
        S_BAW: if (aw_ready) state <= S_BW;
        S_BW: begin
          if (w_ready) begin
            if (beat_last) state <= S_IDLE;
            else cnt <= cnt + 1'b1;
          end
        end
        S_DAW: if (aw_ready) state <= S_DW;
        S_DW:  if (w_ready) state <= S_IDLE;
        default: state <= S_IDLE;
      endcase
    end
  end

  assign idle     = (state == S_IDLE);
  assign rd_tag   = base_r + TAG_W'(cnt);
  assign free_en  = (state == S_BW) && w_ready && rd_hit;

  assign aw_valid = (state == S_BAW) || (state == S_DAW);
  assign aw_addr  = (state == S_DAW) ? dev_addr_r : {base_r, {DW_OFS_W{1'b0}}};
  assign aw_len   = (state == S_BAW) ? 8'(last_r) : 8'd0;
  assign aw_size  = (state == S_BAW) ? AXSIZE_DW : {1'b0, dev_size_r};
  assign aw_burst = BURST_INCR;

  assign w_valid  = (state == S_BW) || (state == S_DW);
  assign w_data   = (state == S_BW) ? rd_data : dev_data_r;
  assign w_strb   = (state == S_BW) ? (rd_hit ? rd_mask : 8'h00) : dev_strb_r;
  assign w_last   = (state == S_DW) || ((state == S_BW) && beat_last);
endmodule

// File: rtl/wmerge_store_buf.sv
module wmerge_store_buf import wsb_pkg::*; #(
  parameter int ADDR_W = 32,
  parameter int NUM_ENT = 4,
  parameter int BLOCK_BEATS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              st_valid,
  output logic              st_ready,
  input  logic [ADDR_W-1:0] st_addr,
  input  logic [1:0]        st_size,
  input  logic [31:0]       st_data,
  input  logic              st_device,
  input  logic              flush,
  output logic              aw_valid,
  input  logic              aw_ready,
  output logic [ADDR_W-1:0] aw_addr,
  output logic [7:0]        aw_len,
  output logic [2:0]        aw_size,
  output logic [1:0]        aw_burst,
  output logic              w_valid,
  input  logic              w_ready,
  output logic [63:0]       w_data,
  output logic [7:0]        w_strb,
  output logic              w_last
);
  localparam int TAG_W  = ADDR_W - DW_OFS_W;
  localparam int BEAT_W = $clog2(BLOCK_BEATS);

  logic [NUM_ENT-1:0]            ent_valid;
  logic [NUM_ENT-1:0][TAG_W-1:0] ent_tag;
  logic              wr_hit, has_free, rd_hit, free_en;
  logic [63:0]       rd_data;
  logic [7:0]        rd_mask;
  logic [TAG_W-1:0]  rd_tag, plan_base;
  logic [BEAT_W-1:0] plan_last;
  logic              any_valid, full, idle, drain_req, wr_en, dev_take;
  logic [7:0]        st_mask;
  logic [63:0]       st_lane;

  assign st_mask   = lane_mask(st_size, st_addr[2:0]);
  assign st_lane   = lane_data(st_data, st_addr[2:0]);
  assign drain_req = any_valid && (full || flush || (st_valid && st_device));
  assign st_ready  = idle && !drain_req &&
                     (st_device ? !any_valid : (wr_hit || has_free));
  assign wr_en     = st_valid && st_ready && !st_device;
  assign dev_take  = st_valid && st_ready && st_device;

  wsb_entry_bank #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W)) u_bank (
    .clk(clk), .rst_n(rst_n),
    .wr_en(wr_en), .wr_tag(st_addr[ADDR_W-1:DW_OFS_W]), .wr_mask(st_mask), .wr_data(st_lane),
    .free_en(free_en), .rd_tag(rd_tag),
    .ent_valid(ent_valid), .ent_tag(ent_tag),
    .wr_hit(wr_hit), .has_free(has_free),
    .rd_hit(rd_hit), .rd_data(rd_data), .rd_mask(rd_mask)
  );

  wsb_burst_plan #(.NUM_ENT(NUM_ENT), .TAG_W(TAG_W), .BEAT_W(BEAT_W)) u_plan (
    .ent_valid(ent_valid), .ent_tag(ent_tag),
    .any_valid(any_valid), .full(full), .base_tag(plan_base), .last_off(plan_last)
  );

  wsb_issue #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .BEAT_W(BEAT_W)) u_issue (
    .clk(clk), .rst_n(rst_n),
    .drain_req(drain_req), .plan_base(plan_base), .plan_last(plan_last),
    .dev_take(dev_take), .dev_addr(st_addr), .dev_size(st_size),
    .dev_data(st_lane), .dev_strb(st_mask),
    .rd_hit(rd_hit), .rd_data(rd_data), .rd_mask(rd_mask),
    .aw_ready(aw_ready), .w_ready(w_ready),
    .idle(idle), .rd_tag(rd_tag), .free_en(free_en),
    .aw_valid(aw_valid), .aw_addr(aw_addr), .aw_len(aw_len), .aw_size(aw_size),
    .aw_burst(aw_burst),
    .w_valid(w_valid), .w_data(w_data), .w_strb(w_strb), .w_last(w_last)
  );
endmodule

// File: rtl/wsb_checker.sv
module wsb_checker #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              st_valid,
  input logic              st_ready,
  input logic              st_device,
  input logic              aw_valid,
  input logic              aw_ready,
  input logic [ADDR_W-1:0] aw_addr,
  input logic [7:0]        aw_len,
  input logic [2:0]        aw_size,
  input logic              w_valid,
  input logic              w_ready,
  input logic [63:0]       w_data,
  input logic [7:0]        w_strb,
  input logic              w_last
);
  logic       aw_done;
  logic [7:0] cur_len;
  logic [2:0] cur_size;
  logic [7:0] beat;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      aw_done  <= 1'b0;
      cur_len  <= '0;
      cur_size <= '0;
      beat     <= '0;
    end else begin
      if (aw_valid && aw_ready) begin
        aw_done  <= 1'b1;
        cur_len  <= aw_len;
        cur_size <= aw_size;
      end
      if (w_valid && w_ready) begin
        if (w_last) begin
          aw_done <= 1'b0;
          beat    <= '0;
        end else begin
          beat <= beat + 8'd1;
        end
      end
    end
  end

  assert_aw_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid && !aw_ready |=> aw_valid && $stable(aw_addr) && $stable(aw_len) && $stable(aw_size));

  assert_w_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid && !w_ready |=> w_valid && $stable(w_data) && $stable(w_strb) && $stable(w_last));

  assert_w_after_aw_R11: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid |-> aw_done);

  assert_one_aw_open_R11: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid |-> !aw_done);

  assert_last_beat_R11: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid |-> (w_last == (beat == cur_len)));

  assert_dev_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    aw_valid && aw_size != 3'd3 |-> aw_len == 8'd0);

  assert_dev_strb_R3: assert property (@(posedge clk) disable iff (!rst_n)
    w_valid && cur_size != 3'd3 |-> $countones(w_strb) == (32'd1 << cur_size));

  assert_dev_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
    st_valid && st_ready && st_device |-> !aw_valid && !w_valid);
endmodule

bind wmerge_store_buf wsb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready), .st_device(st_device),
  .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
  .aw_size(aw_size), .w_valid(w_valid), .w_ready(w_ready), .w_data(w_data),
  .w_strb(w_strb), .w_last(w_last)
);

// File: tb/sim_wmerge_store_buf.sv
module sim_wmerge_store_buf;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic st_valid = 1'b0, st_device = 1'b0, flush = 1'b0;
  logic [31:0] st_addr = '0, st_data = '0;
  logic [1:0]  st_size = '0;
  logic st_ready, aw_valid, aw_ready, w_valid, w_ready, w_last;
  logic [31:0] aw_addr;
  logic [7:0]  aw_len, w_strb;
  logic [2:0]  aw_size;
  logic [1:0]  aw_burst;
  logic [63:0] w_data;

  logic bp = 1'b0;
  logic [7:0] cyc = '0;
  int n_chk = 0, n_fail = 0;
  int aw_n = 0, w_n = 0;
  logic [31:0] aw_a_log [64];
  logic [7:0]  aw_l_log [64];
  logic [2:0]  aw_s_log [64];
  logic [1:0]  aw_b_log [64];
  logic [63:0] w_d_log [64];
  logic [7:0]  w_s_log [64];
  logic        w_l_log [64];

  always #5 clk = ~clk;

  assign aw_ready = !bp || cyc[1];
  assign w_ready  = !bp || (cyc[1:0] != 2'd0);

  always @(posedge clk) begin
    #3 cyc <= cyc + 8'd1;
  end

  wmerge_store_buf u0 (
    .clk(clk), .rst_n(rst_n), .st_valid(st_valid), .st_ready(st_ready), .st_addr(st_addr),
    .st_size(st_size), .st_data(st_data), .st_device(st_device), .flush(flush),
    .aw_valid(aw_valid), .aw_ready(aw_ready), .aw_addr(aw_addr), .aw_len(aw_len),
    .aw_size(aw_size), .aw_burst(aw_burst), .w_valid(w_valid), .w_ready(w_ready),
    .w_data(w_data), .w_strb(w_strb), .w_last(w_last)
  );

  always @(negedge clk) begin
    if (aw_valid && aw_ready) begin
      if (aw_n < 64) begin
        aw_a_log[aw_n] = aw_addr; aw_l_log[aw_n] = aw_len;
        aw_s_log[aw_n] = aw_size; aw_b_log[aw_n] = aw_burst;
      end
      aw_n++;
    end
    if (w_valid && w_ready) begin
      if (w_n < 64) begin
        w_d_log[w_n] = w_data; w_s_log[w_n] = w_strb; w_l_log[w_n] = w_last;
      end
      w_n++;
    end
  end

  function automatic logic [63:0] bytes_of(input logic [7:0] m);
    logic [63:0] r;
    for (int b = 0; b < 8; b++) r[b*8 +: 8] = {8{m[b]}};
    return r;
  endfunction

  task automatic check(input string req, input string what, input logic [63:0] act,
                       input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  task automatic expect_aw(input int i, input logic [31:0] a, input logic [7:0] l,
                           input logic [2:0] s, input string req);
    check(req, "aw_addr", 64'(aw_a_log[i]), 64'(a));
    check(req, "aw_len", 64'(aw_l_log[i]), 64'(l));
    check(req, "aw_size", 64'(aw_s_log[i]), 64'(s));
    check(req, "aw_burst", 64'(aw_b_log[i]), 64'(2'b01));
  endtask

  task automatic expect_w(input int i, input logic [7:0] s, input logic [63:0] d,
                          input logic l, input string req);
    check(req, "w_strb", 64'(w_s_log[i]), 64'(s));
    check(req, "w_data", w_d_log[i] & bytes_of(s), d & bytes_of(s));
    check(req, "w_last", 64'(w_l_log[i]), 64'(l));
  endtask

  task automatic put(input logic [31:0] a, input logic [1:0] sz, input logic [31:0] d,
                     input logic dev);
    @(negedge clk);
    st_addr = a; st_size = sz; st_data = d; st_device = dev; st_valid = 1'b1;
    #2;
    while (!st_ready) begin
      @(negedge clk);
      #2;
    end
    @(negedge clk);
    st_valid = 1'b0;
  endtask

  task automatic wait_counts(input int na, input int nw);
    int t = 0;
    while ((aw_n < na || w_n < nw) && t < 400) begin
      @(negedge clk);
      t++;
    end
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    @(negedge clk);
    #2;
    check("R1", "st_ready after reset", 64'(st_ready), 64'd1);
    check("R9", "aw_valid after reset", 64'(aw_valid), 64'd0);
    check("R11", "w_valid after reset", 64'(w_valid), 64'd0);
  endtask

  task automatic t_merge_example;
    int a0 = aw_n, w0 = w_n;
    put(32'h4018, 2'd1, 32'h0000_1111, 1'b0);
    put(32'h400C, 2'd2, 32'h2222_2222, 1'b0);
    put(32'h4000, 2'd2, 32'h4444_4444, 1'b0);
    put(32'h4004, 2'd2, 32'h5555_5555, 1'b0);
    put(32'h4008, 2'd2, 32'h6666_6666, 1'b0);
    put(32'h400C, 2'd2, 32'h7777_7777, 1'b0);
    put(32'h401D, 2'd0, 32'h0000_0033, 1'b0);
    repeat (20) @(negedge clk);
    check("R9", "no drain without trigger", 64'(aw_n - a0), 64'd0);
    flush = 1'b1;
    wait_counts(a0 + 1, w0 + 4);
    flush = 1'b0;
    check("R7", "one burst", 64'(aw_n - a0), 64'd1);
    expect_aw(a0, 32'h4000, 8'd3, 3'd3, "R7");
    expect_w(w0,     8'hFF, 64'h5555_5555_4444_4444, 1'b0, "R5");
    expect_w(w0 + 1, 8'hFF, 64'h7777_7777_6666_6666, 1'b0, "R6");
    expect_w(w0 + 2, 8'h00, 64'h0, 1'b0, "R8");
    expect_w(w0 + 3, 8'h23, 64'h0000_3300_0000_1111, 1'b1, "R5");
  endtask

  task automatic t_device;
    int a0 = aw_n, w0 = w_n;
    put(32'h4018, 2'd1, 32'h0000_1111, 1'b1);
    put(32'h400C, 2'd2, 32'h2222_2222, 1'b1);
    put(32'h4000, 2'd2, 32'h4444_4444, 1'b1);
    put(32'h4004, 2'd2, 32'h5555_5555, 1'b1);
    put(32'h4008, 2'd2, 32'h6666_6666, 1'b1);
    put(32'h400C, 2'd2, 32'h7777_7777, 1'b1);
    put(32'h401D, 2'd0, 32'h0000_0033, 1'b1);
    wait_counts(a0 + 7, w0 + 7);
    check("R4", "device transaction count", 64'(aw_n - a0), 64'd7);
    expect_aw(a0,     32'h4018, 8'd0, 3'd1, "R2");
    expect_aw(a0 + 1, 32'h400C, 8'd0, 3'd2, "R4");
    expect_aw(a0 + 2, 32'h4000, 8'd0, 3'd2, "R4");
    expect_aw(a0 + 5, 32'h400C, 8'd0, 3'd2, "R4");
    expect_aw(a0 + 6, 32'h401D, 8'd0, 3'd0, "R2");
    expect_w(w0,     8'h03, 64'h0000_1111, 1'b1, "R3");
    expect_w(w0 + 1, 8'hF0, 64'h2222_2222_0000_0000, 1'b1, "R3");
    expect_w(w0 + 3, 8'hF0, 64'h5555_5555_0000_0000, 1'b1, "R4");
    expect_w(w0 + 6, 8'h20, 64'h0000_3300_0000_0000, 1'b1, "R3");
  endtask

  task automatic t_full;
    int a0 = aw_n, w0 = w_n;
    put(32'h3000, 2'd0, 32'hA3, 1'b0);
    put(32'h1000, 2'd0, 32'hA1, 1'b0);
    put(32'h4000, 2'd0, 32'hA4, 1'b0);
    put(32'h2000, 2'd0, 32'hA2, 1'b0);
    repeat (30) @(negedge clk);
    check("R9", "full drains one burst", 64'(aw_n - a0), 64'd1);
    expect_aw(a0, 32'h1000, 8'd0, 3'd3, "R7");
    expect_w(w0, 8'h01, 64'hA1, 1'b1, "R9");
    flush = 1'b1;
    wait_counts(a0 + 4, w0 + 4);
    flush = 1'b0;
    expect_aw(a0 + 1, 32'h2000, 8'd0, 3'd3, "R7");
    expect_aw(a0 + 2, 32'h3000, 8'd0, 3'd3, "R7");
    expect_aw(a0 + 3, 32'h4000, 8'd0, 3'd3, "R7");
    expect_w(w0 + 3, 8'h01, 64'hA4, 1'b1, "R7");
  endtask

  task automatic t_dev_after_normal;
    int a0 = aw_n, w0 = w_n;
    put(32'h5008, 2'd2, 32'hCAFE_F00D, 1'b0);
    @(negedge clk);
    st_addr = 32'h0100; st_size = 2'd2; st_data = 32'h1234_5678; st_device = 1'b1;
    st_valid = 1'b1;
    #2;
    check("R10", "device held while entries buffered", 64'(st_ready), 64'd0);
    put(32'h0100, 2'd2, 32'h1234_5678, 1'b1);
    wait_counts(a0 + 2, w0 + 2);
    expect_aw(a0, 32'h5008, 8'd0, 3'd3, "R10");
    expect_w(w0, 8'h0F, 64'hCAFE_F00D, 1'b1, "R10");
    expect_aw(a0 + 1, 32'h0100, 8'd0, 3'd2, "R10");
    expect_w(w0 + 1, 8'h0F, 64'h1234_5678, 1'b1, "R2");
  endtask

  task automatic t_backpressure;
    int a0 = aw_n, w0 = w_n;
    bp = 1'b1;
    put(32'h6018, 2'd1, 32'h0000_BEEF, 1'b0);
    put(32'h6020, 2'd2, 32'h0102_0304, 1'b0);
    put(32'h6024, 2'd2, 32'h0506_0708, 1'b0);
    put(32'h6038, 2'd0, 32'h0000_0099, 1'b0);
    flush = 1'b1;
    repeat (2) @(negedge clk);
    st_addr = 32'h7000; st_size = 2'd0; st_data = 32'h55; st_device = 1'b0; st_valid = 1'b1;
    #2;
    check("R1", "store blocked during drain", 64'(st_ready), 64'd0);
    @(negedge clk);
    st_valid = 1'b0;
    wait_counts(a0 + 2, w0 + 5);
    flush = 1'b0;
    bp = 1'b0;
    check("R11", "beat count under stall", 64'(w_n - w0), 64'd5);
    expect_aw(a0, 32'h6018, 8'd0, 3'd3, "R12");
    expect_w(w0, 8'h03, 64'hBEEF, 1'b1, "R12");
    expect_aw(a0 + 1, 32'h6020, 8'd3, 3'd3, "R7");
    expect_w(w0 + 1, 8'hFF, 64'h0506_0708_0102_0304, 1'b0, "R12");
    expect_w(w0 + 2, 8'h00, 64'h0, 1'b0, "R8");
    expect_w(w0 + 3, 8'h00, 64'h0, 1'b0, "R8");
    expect_w(w0 + 4, 8'h01, 64'h99, 1'b1, "R11");
  endtask

  task automatic report;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_merge_example();
    t_device();
    t_full();
    t_dev_after_normal();
    t_backpressure();
    report();
  end
endmodule